// File: doc/BRIEF.md
# Timer Interrupt Status Capture Unit

This block sits between eight timer counter channels and the processor bus. Each channel raises a one-cycle expiry pulse. The block answers each pulse in two ways. It inverts that channel's interrupt output level, so each expiry is signalled as an edge rather than as a pulse. It also sets a sticky status bit for that channel, and the bit stays set until software removes it. Channel n always owns status bit n.

Software reaches the block through a simple 32-bit register port with an 8-bit byte offset:

- **Status register, offset 0x34.** Software clears status bits by writing a keep-mask: every status bit whose write-data bit is 0 is dropped.
- **Global control word, offset 0x30.** The block holds this word and drives it out to the counter logic.
- **Clear alias, offset 0x3C.** It clears control bits at once, with no unlock sequence.
- **Other offsets.** Offset 0x38 and every offset not listed above are inert.

Read data comes back registered, in the cycle after the read strobe.

Top module: `tmr_irq_status_unit`

## Requirements
- R1: A synchronous active-high reset sets the control word, every status bit, every interrupt level and the read data to zero.
- R2: An expiry pulse on channel n inverts `irq_level[n]` at the next clock edge. A channel with no pulse keeps its level.
- R3: An expiry pulse on channel n sets status bit n at the next clock edge. The bit stays 1 until a status write clears it.
- R4: A read with `bus_addr` = 0x34 returns the status bits in `bus_rdata[7:0]` and zero in `bus_rdata[31:8]`, one cycle after `bus_rd`.
- R5: A write with `bus_addr` = 0x34 replaces the status with status AND `bus_wdata[7:0]`.
- R6: When an expiry pulse and a status write that would clear the same bit land in the same cycle, the bit ends up set.
- R7: Offset 0x30 is a read/write control register. Its value is also driven on `ctrl_word`.
- R8: A write to offset 0x3C clears each control bit whose `bus_wdata` bit is 1 and leaves the other control bits unchanged.
- R9: Reads of offset 0x38, or of any offset other than 0x30, 0x34 and 0x3C, return zero. Writes to those offsets change neither the control word nor the status.
- R10: Pulses on several channels in the same cycle are each captured, both in status and in level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| expire_pulse | input | 8 | One-cycle expiry pulse per channel |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (never asserted together with `bus_wr`) |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_level | output | 8 | Toggling interrupt line per channel |
| ctrl_word | output | 32 | Global control register value |

## Verification
The embedded assertions check, on every cycle:

- each level inverts on a pulse and holds without one;
- a pulse always leaves its status bit set;
- a status bit only falls on a status write;
- the clear alias leaves no selected control bit set;
- the control word holds when no control write occurs;
- inert or unmapped reads return zero.

Only the bench scenarios show the exact data values. These include the AND-mask result of a status write, multi-channel captures, full control readback, and the fact that writes to inert offsets leave the status and control contents unchanged.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
    parameter int NUM_CH  = 8;
    parameter int DATA_W  = 32;
    parameter int ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_INERT  = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_CCLR   = 8'h3C;

    typedef struct packed {
        logic wr_ctrl;
        logic wr_status;
        logic wr_cclr;
        logic rd_ctrl;
        logic rd_status;
    } bus_op_t;

    function automatic bus_op_t decode_op(input logic wr, input logic rd,
                                          input logic [ADDR_W-1:0] addr);
        bus_op_t op;
        op.wr_ctrl   = wr && (addr == OFS_CTRL);
        op.wr_status = wr && (addr == OFS_STATUS);
        op.wr_cclr   = wr && (addr == OFS_CCLR);
        op.rd_ctrl   = rd && (addr == OFS_CTRL);
        op.rd_status = rd && (addr == OFS_STATUS);
        return op;
    endfunction
endpackage

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic status_wr,
    input  logic keep_bit,
    output logic level,
    output logic sticky
);
    always_ff @(posedge clk) begin
        if (rst) begin
            level  <= 1'b0;
            sticky <= 1'b0;
        end else begin
            if (expire)
                level <= ~level;
            if (expire)
                sticky <= 1'b1;
            else if (status_wr)
                sticky <= sticky & keep_bit;
        end
    end

    AST_LEVEL_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        expire |=> (level != $past(level)));  // R2
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !expire |=> $stable(level));  // R2
    AST_STICKY_KEPT: assert property (@(posedge clk) disable iff (rst)
        (sticky && !status_wr) |=> sticky);  // R3
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        expire |=> sticky);  // R6
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
    import tmr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q
);
    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (load)
            ctrl_q <= wdata;
        else if (clear)
            ctrl_q <= ctrl_q & ~wdata;
    end

    AST_CLEAR_ALIAS: assert property (@(posedge clk) disable iff (rst)
        clear |=> ((ctrl_q & $past(wdata)) == '0));  // R8
    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !clear) |=> $stable(ctrl_q));  // R9
endmodule

// File: rtl/tmr_irq_status_unit.sv
module tmr_irq_status_unit
    import tmr_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] expire_pulse,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq_level,
    output logic [DATA_W-1:0] ctrl_word
);
    bus_op_t           op;
    logic [NUM_CH-1:0] status_bits;
    logic [DATA_W-1:0] rd_mux;

    assign op = decode_op(bus_wr, bus_rd, bus_addr);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        tmr_irq_chan u_chan (
            .clk       (clk),
            .rst       (rst),
            .expire    (expire_pulse[ch]),
            .status_wr (op.wr_status),
            .keep_bit  (bus_wdata[ch]),
            .level     (irq_level[ch]),
            .sticky    (status_bits[ch])
        );
    end

    tmr_irq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .load   (op.wr_ctrl),
        .clear  (op.wr_cclr),
        .wdata  (bus_wdata),
        .ctrl_q (ctrl_word)
    );

    always_comb begin
        rd_mux = '0;
        if (op.rd_ctrl)
            rd_mux = ctrl_word;
        else if (op.rd_status)
            rd_mux[NUM_CH-1:0] = status_bits;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else
            bus_rdata <= rd_mux;
    end

    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_STATUS) |=> (bus_rdata[DATA_W-1:NUM_CH] == '0));  // R4
    AST_INERT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr != OFS_STATUS && bus_addr != OFS_CTRL) |=> (bus_rdata == '0));  // R9
    AST_STATUS_ONLY_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == OFS_STATUS) |=> ((status_bits & $past(status_bits)) == $past(status_bits)));  // R3
endmodule

// File: tb/tmr_irq_status_unit_bench.sv
`timescale 1ns/1ps
module tmr_irq_status_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  expire_pulse = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq_level;
    logic [31:0] ctrl_word;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    logic [7:0]  m_irq = '0;
    logic [7:0]  m_stat = '0;
    logic [31:0] m_ctrl = '0;

    always #10 clk = ~clk;

    tmr_irq_status_unit u_tmr_irq_status_unit (
        .clk(clk), .rst(rst), .expire_pulse(expire_pulse),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level(irq_level), .ctrl_word(ctrl_word)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: pop expected read data once the registered result is visible
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                checks++; failures++;
                $display("FAIL scoreboard underflow actual=%h expected=none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] pulse);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; expire_pulse = pulse;
        tick();
        bus_wr = 1'b0; expire_pulse = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        expire_pulse = m;
        tick();
        expire_pulse = '0;
        m_irq  = m_irq ^ m;
        m_stat = m_stat | m;
    endtask

    initial begin
        #(20.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk); tick(); tick();
        rst = 1'b0;
        chk({24'h0, irq_level}, 32'h0, "R1 irq after reset");
        chk(ctrl_word, 32'h0, "R1 ctrl after reset");
        rd(8'h34, 32'h0, "R1 status after reset");

        pulse(8'h01);
        chk({24'h0, irq_level}, {24'h0, m_irq}, "R2 first toggle");
        rd(8'h34, {24'h0, m_stat}, "R3 status set");
        pulse(8'h01);
        chk({24'h0, irq_level}, {24'h0, m_irq}, "R2 toggle back");
        rd(8'h34, {24'h0, m_stat}, "R3 sticky kept");

        pulse(8'hA5);
        chk({24'h0, irq_level}, {24'h0, m_irq}, "R10 multi levels");
        rd(8'h34, {24'h0, m_stat}, "R10 multi status");

        wr(8'h34, 32'hFFFF_FF0F, 8'h00);
        m_stat = m_stat & 8'h0F;
        rd(8'h34, {24'h0, m_stat}, "R5 and-mask clear");
        chk(32'h5, {24'h0, m_stat}, "R5 model value");

        wr(8'h34, 32'h0, 8'h04);
        m_irq = m_irq ^ 8'h04; m_stat = 8'h04;
        rd(8'h34, 32'h4, "R6 set wins");
        chk({24'h0, irq_level}, {24'h0, m_irq}, "R2 level with write");

        wr(8'h30, 32'hDEAD_BEEF, 8'h00); m_ctrl = 32'hDEAD_BEEF;
        chk(ctrl_word, m_ctrl, "R7 ctrl out");
        rd(8'h30, m_ctrl, "R7 ctrl readback");

        wr(8'h3C, 32'h0000_FFFF, 8'h00); m_ctrl = 32'hDEAD_0000;
        chk(ctrl_word, m_ctrl, "R8 alias clear");
        rd(8'h30, m_ctrl, "R8 alias readback");

        wr(8'h38, 32'hFFFF_FFFF, 8'h00);
        rd(8'h38, 32'h0, "R9 inert read");
        rd(8'h30, m_ctrl, "R9 ctrl untouched");
        rd(8'h34, {24'h0, m_stat}, "R9 status untouched");
        wr(8'h10, 32'h0, 8'h00);
        rd(8'h10, 32'h0, "R9 unmapped read");
        rd(8'h34, {24'h0, m_stat}, "R9 status after unmapped write");
        chk(ctrl_word, m_ctrl, "R9 ctrl after unmapped write");

        pulse(8'hFF);
        rd(8'h34, 32'hFF, "R10 all channels");
        chk({24'h0, irq_level}, {24'h0, m_irq}, "R10 all levels");

        rst = 1'b1; tick(); rst = 1'b0;
        chk({24'h0, irq_level}, 32'h0, "R1 irq after mid reset");
        chk(ctrl_word, 32'h0, "R1 ctrl after mid reset");
        rd(8'h34, 32'h0, "R1 status after mid reset");

        tick();
        chk(exp_q.size(), 0, "scoreboard drained R4");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule